// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Interface

This controller collects up to 96 interrupt requests, organised as banks of 32, and presents them to a processor through one interrupt line and a set of word registers. Every source has three pieces of state: a pending bit, an enable bit and a mask bit. A source is active when it is pending and enabled and not masked. The processor line is raised whenever any source is active. A vector register names the active source with the lowest number, so the handler learns which source to serve with a single read.

Source 0 is the external non-maskable-style input, and it is handled differently from the others. The vector register reads zero in two cases: when nothing is active, and when source 0 wins. For this reason source 0 keeps a latched pending bit that software reads to tell the two cases apart, and clears with a write-one. The other sources are level-sensitive. After a two-stage synchronizer their pending bits follow the request lines, and they need no acknowledge. A protection register and a trigger-control register for source 0 complete the map. A build parameter moves the enable and mask banks to a more compact alternate layout.

The bus is a simple strobe interface: byte addresses with the two low bits ignored, a write strobe, a read strobe, and read data that is registered.

Top module: `vic_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, every register clears to zero. After reset, `cpu_irq_o` is low and `bus_rdata` reads zero.
- R2: Sources 1 to 95 are level-sensitive. The pending bit of source n sits in the pending word at byte 0x10 + 4*(n/32), bit n%32, and it equals that request input delayed by three clock edges (two synchronizer stages and the pending register). Writes to these pending bits have no effect.
- R3: Source 0 latches a rising edge while the trigger field at 0x0C is 0. A rising edge of the synchronized input sets bit 0 of the pending word at 0x10. The bit stays set until a write to 0x10 with data bit 0 = 1 clears it. If an edge and that write arrive in the same cycle, the edge wins. An input that stays high does not set the bit again after it is acknowledged.
- R4: When the trigger field at 0x0C is not zero, source 0 works in level mode. Its pending bit is set on every cycle in which the synchronized input is high, so an acknowledge takes effect only once the input is low.
- R5: In the default layout the enable words are at 0x40 + 4*bank and the mask words at 0x50 + 4*bank. Both are read/write. A source is active when its pending bit is 1, its enable bit is 1 and its mask bit is 0.
- R6: With ALT_LAYOUT = 1, the enable words move to 0x20 + 4*bank and the mask words to 0x30 + 4*bank. In the default layout, the fast-pending words at 0x20 + 4*bank read zero and ignore writes. In each layout, the other layout's enable and mask offsets are unmapped.
- R7: `cpu_irq_o` is high in exactly those cycles in which at least one source is active.
- R8: The word at 0x00 returns the lowest-numbered active source in bits [8:2], with all other bits zero. It reads zero when no source is active, and writes to it are ignored.
- R9: At 0x08, bit 0 holds the protection flag. At 0x0C, bits [1:0] hold the source-0 trigger field. Both are read/write, and their unused bits read zero.
- R10: `bus_rdata` takes the value of the addressed register on the clock edge that samples `bus_rd`, and holds it until the next read. Unmapped addresses read zero, and `bus_addr[1:0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src_i | input | NUM_BANKS*32 (96) | Asynchronous interrupt request lines, source n on bit n |
| cpu_irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds two copies of the controller, both with three banks and a 2-bit trigger field. One copy uses the default layout and the other sets ALT_LAYOUT to 1, and both receive the same bus traffic. Each write to an enable or mask offset therefore hits a live register in one copy and an unmapped or fast-pending slot in the other, which checks both the relocation and the ignore behaviour in the same run. Because there are three banks, the bench can reach the source with the highest number (95) as well as the boundaries between banks. It can also reach source 0 colliding with a higher source in the vector, in both trigger modes.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int WORD_W     = 32;
    localparam int BANK_SEL_W = 2;
    localparam int WADDR_W    = 6;

    // word offsets that do not move between layouts
    localparam int W_VEC  = 0;
    localparam int W_PROT = 2;
    localparam int W_TRIG = 3;
    localparam int W_PEND = 4;
    localparam int W_FAST = 8;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_VEC,
        RG_PROT,
        RG_TRIG,
        RG_PEND,
        RG_FAST,
        RG_EN,
        RG_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e               kind;
        logic [BANK_SEL_W-1:0]   bank;
    } reg_sel_t;

    typedef struct packed {
        logic              wr_en;
        logic              wr_mask;
        logic              ack0;
        logic [WORD_W-1:0] data;
    } bank_wr_t;

    typedef struct packed {
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] en;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] active;
    } bank_view_t;

    function automatic int en_base(bit alt);
        return alt ? 8 : 16;
    endfunction

    function automatic int mask_base(bit alt);
        return alt ? 12 : 20;
    endfunction

    function automatic reg_sel_t decode_addr(logic [WADDR_W-1:0] w, bit alt, int nb);
        reg_sel_t s;
        int       wi;
        int       eb;
        int       mb;
        wi     = int'(w);
        eb     = en_base(alt);
        mb     = mask_base(alt);
        s.kind = RG_NONE;
        s.bank = '0;
        if (wi == W_VEC) begin
            s.kind = RG_VEC;
        end else if (wi == W_PROT) begin
            s.kind = RG_PROT;
        end else if (wi == W_TRIG) begin
            s.kind = RG_TRIG;
        end else if (wi >= W_PEND && wi < W_PEND + nb) begin
            s.kind = RG_PEND;
            s.bank = BANK_SEL_W'(wi - W_PEND);
        end else if (!alt && wi >= W_FAST && wi < W_FAST + nb) begin
            s.kind = RG_FAST;
            s.bank = BANK_SEL_W'(wi - W_FAST);
        end else if (wi >= eb && wi < eb + nb) begin
            s.kind = RG_EN;
            s.bank = BANK_SEL_W'(wi - eb);
        end else if (wi >= mb && wi < mb + nb) begin
            s.kind = RG_MASK;
            s.bank = BANK_SEL_W'(wi - mb);
        end
        return s;
    endfunction

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W      = 96,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= '0;
                else     stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= '0;
                else     stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/vic_bank.sv
module vic_bank
    import vic_pkg::*;
#(
    parameter bit HAS_NMI = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] lvl_i,
    input  logic              nmi_edge_mode_i,
    input  bank_wr_t          wr_i,
    output bank_view_t        view_o
);

    logic [WORD_W-1:0] en_q;
    logic [WORD_W-1:0] mask_q;
    logic [WORD_W-1:0] pend_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            if (wr_i.wr_en)   en_q   <= wr_i.data;
            if (wr_i.wr_mask) mask_q <= wr_i.data;
        end
    end

    if (HAS_NMI) begin : g_nmi
        logic              prev_q;
        logic              pend0_q;
        logic              set0;
        logic [WORD_W-1:1] pend_hi_q;

        assign set0 = nmi_edge_mode_i ? (lvl_i[0] & ~prev_q) : lvl_i[0];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q  <= 1'b0;
                pend0_q <= 1'b0;
            end else begin
                prev_q <= lvl_i[0];
                if (set0)           pend0_q <= 1'b1;
                else if (wr_i.ack0) pend0_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) pend_hi_q <= '0;
            else     pend_hi_q <= lvl_i[WORD_W-1:1];
        end

        assign pend_w = {pend_hi_q, pend0_q};

        // R3: a fresh rising edge in edge mode is captured
        p_edge_capture_r3: assert property (@(posedge clk) disable iff (rst)
            (nmi_edge_mode_i && lvl_i[0] && !prev_q) |=> view_o.pend[0]);

        // R3: acknowledge without a new edge clears the latch
        p_ack_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (nmi_edge_mode_i && wr_i.ack0 && !(lvl_i[0] && !prev_q)) |=> !view_o.pend[0]);

        // R4: level mode keeps the bit set while the input is high
        p_level_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (!nmi_edge_mode_i && lvl_i[0]) |=> view_o.pend[0]);

        // R2: upper sources follow the synchronized level
        p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
            !rst |=> view_o.pend[WORD_W-1:1] == $past(lvl_i[WORD_W-1:1]));
    end else begin : g_plain
        logic [WORD_W-1:0] pend_q;
        logic              unused_nmi_ctl;

        always_ff @(posedge clk) begin
            if (rst) pend_q <= '0;
            else     pend_q <= lvl_i;
        end

        assign pend_w         = pend_q;
        assign unused_nmi_ctl = nmi_edge_mode_i ^ wr_i.ack0;

        // R2: every bit of a plain bank follows the synchronized level
        p_bank_follow_r2: assert property (@(posedge clk) disable iff (rst)
            !rst |=> view_o.pend == $past(lvl_i));
    end

    assign view_o.pend   = pend_w;
    assign view_o.en     = en_q;
    assign view_o.mask   = mask_q;
    assign view_o.active = pend_w & en_q & ~mask_q;

    // R5: an enable write lands in the following cycle
    p_en_write_r5: assert property (@(posedge clk) disable iff (rst)
        wr_i.wr_en |=> view_o.en == $past(wr_i.data));

    // R5: mask bits change only on a mask write
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_i.wr_mask |=> $stable(view_o.mask));

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N     = 96,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    parameter bit ALT_LAYOUT = 1'b0,
    parameter int TRIG_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [7:0]                  bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_BANKS*32-1:0]     irq_src_i,
    output logic                        cpu_irq_o
);

    localparam int NUM_SRC = NUM_BANKS * WORD_W;
    localparam int IDX_W   = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] active_all;
    logic [NUM_SRC-1:0] pend_all;
    logic [NUM_SRC-1:0] en_all;
    logic [NUM_SRC-1:0] mask_all;
    logic [NUM_SRC-1:0] below_win;
    logic [IDX_W-1:0]   win_idx;
    logic               win_any;
    reg_sel_t           sel;
    logic               prot_q;
    logic [TRIG_W-1:0]  trig_q;
    logic               nmi_edge;
    logic [WORD_W-1:0]  rd_d;
    logic               unused_addr_lsb;
    bank_view_t         view [NUM_BANKS];
    bank_wr_t           bwr  [NUM_BANKS];

    assign unused_addr_lsb = ^bus_addr[1:0];

    vic_sync #(
        .W      (NUM_SRC),
        .STAGES (2)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (irq_src_i),
        .q_o (src_sync)
    );

    assign sel      = decode_addr(bus_addr[7:2], ALT_LAYOUT, NUM_BANKS);
    assign nmi_edge = (trig_q == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bwr[b].wr_en   = bus_wr && sel.kind == RG_EN   && sel.bank == BANK_SEL_W'(b);
        assign bwr[b].wr_mask = bus_wr && sel.kind == RG_MASK && sel.bank == BANK_SEL_W'(b);
        assign bwr[b].ack0    = (b == 0) && bus_wr && sel.kind == RG_PEND
                                && sel.bank == '0 && bus_wdata[0];
        assign bwr[b].data    = bus_wdata;

        vic_bank #(
            .HAS_NMI (b == 0)
        ) u_bank (
            .clk             (clk),
            .rst             (rst),
            .lvl_i           (src_sync[b*WORD_W +: WORD_W]),
            .nmi_edge_mode_i (nmi_edge),
            .wr_i            (bwr[b]),
            .view_o          (view[b])
        );

        assign active_all[b*WORD_W +: WORD_W] = view[b].active;
        assign pend_all[b*WORD_W +: WORD_W]   = view[b].pend;
        assign en_all[b*WORD_W +: WORD_W]     = view[b].en;
        assign mask_all[b*WORD_W +: WORD_W]   = view[b].mask;
    end

    vic_prio #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_prio (
        .req_i (active_all),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    assign cpu_irq_o = win_any;
    assign below_win = (NUM_SRC'(1) << win_idx) - NUM_SRC'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= 1'b0;
            trig_q <= '0;
        end else if (bus_wr) begin
            if (sel.kind == RG_PROT) prot_q <= bus_wdata[0];
            if (sel.kind == RG_TRIG) trig_q <= bus_wdata[TRIG_W-1:0];
        end
    end

    always_comb begin
        rd_d = '0;
        case (sel.kind)
            RG_VEC:  rd_d = WORD_W'(win_idx) << 2;
            RG_PROT: rd_d = WORD_W'(prot_q);
            RG_TRIG: rd_d = WORD_W'(trig_q);
            RG_PEND, RG_EN, RG_MASK: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (sel.bank == BANK_SEL_W'(b)) begin
                        if (sel.kind == RG_PEND)     rd_d = view[b].pend;
                        else if (sel.kind == RG_EN)  rd_d = view[b].en;
                        else                         rd_d = view[b].mask;
                    end
                end
            end
            default: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_d;
    end

    // R7: a raised line always has a pending, enabled, unmasked winner
    p_winner_valid_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_irq_o |-> (pend_all[win_idx] && en_all[win_idx] && !mask_all[win_idx]));

    // R8: no lower-numbered source is active than the reported one
    p_none_lower_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_irq_o |-> (active_all & below_win) == '0);

    // R8: idle controller reports vector zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !cpu_irq_o |-> win_idx == '0);

    // R9: protection flag changes only on its own write
    p_prot_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel.kind == RG_PROT) |=> $stable(prot_q));

    // R10: read data holds between read strobes
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/vic_ctrl_bench.sv
module vic_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        wr;
    logic        rd;
    logic [31:0] wdata;
    logic [95:0] src;
    logic [31:0] rdata [2];
    logic        irq   [2];

    always #5 clk = ~clk;

    vic_ctrl u_vic_ctrl (
        .clk (clk), .rst (rst), .bus_addr (addr), .bus_wr (wr), .bus_rd (rd),
        .bus_wdata (wdata), .bus_rdata (rdata[0]), .irq_src_i (src), .cpu_irq_o (irq[0])
    );

    vic_ctrl #(.ALT_LAYOUT(1'b1)) u_vic_ctrl_alt (
        .clk (clk), .rst (rst), .bus_addr (addr), .bus_wr (wr), .bus_rd (rd),
        .bus_wdata (wdata), .bus_rdata (rdata[1]), .irq_src_i (src), .cpu_irq_o (irq[1])
    );

    // behavioural reference state
    bit          m_pend [96];
    bit          m_en   [2][96];
    bit          m_mk   [2][96];
    bit          m_s1   [96];
    bit          m_s2   [96];
    bit          m_s3;
    bit          m_prot;
    int          m_trig;
    logic [31:0] m_rd   [2];
    int          m_last_addr;
    int          vecs;
    int          fails;
    int          cyc;
    bit          started;
    bit          finished;

    function automatic bit m_active(int inst, int n);
        return m_pend[n] && m_en[inst][n] && !m_mk[inst][n];
    endfunction

    function automatic logic [31:0] m_read(int inst, int a);
        int          w;
        int          eb;
        int          mb;
        logic [31:0] r;
        w  = a / 4;
        eb = (inst == 1) ? 8 : 16;
        mb = (inst == 1) ? 12 : 20;
        r  = '0;
        if (w == 0) begin
            for (int n = 95; n >= 0; n--) if (m_active(inst, n)) r = 32'(n * 4);
        end else if (w == 2) begin
            r = 32'(m_prot);
        end else if (w == 3) begin
            r = 32'(m_trig);
        end else if (w >= 4 && w < 7) begin
            for (int k = 0; k < 32; k++) r[k] = m_pend[(w - 4) * 32 + k];
        end else if (w >= eb && w < eb + 3) begin
            for (int k = 0; k < 32; k++) r[k] = m_en[inst][(w - eb) * 32 + k];
        end else if (w >= mb && w < mb + 3) begin
            for (int k = 0; k < 32; k++) r[k] = m_mk[inst][(w - mb) * 32 + k];
        end
        return r;
    endfunction

    function automatic string tag_of(int inst, int a);
        int w;
        w = a / 4;
        if (w == 0)                  return "R8";
        if (w == 2 || w == 3)        return "R9";
        if (w >= 4 && w < 7)         return "R2/R3/R4";
        if (inst == 0 && (w >= 16 && w < 23)) return "R5";
        if (inst == 1 && (w >= 8 && w < 15))  return "R6";
        return "R10";
    endfunction

    always @(posedge clk) begin
        bit set0;
        bit ack;
        int w;
        if (rst) begin
            for (int n = 0; n < 96; n++) begin
                m_pend[n] = 0; m_s1[n] = 0; m_s2[n] = 0;
                for (int i = 0; i < 2; i++) begin m_en[i][n] = 0; m_mk[i][n] = 0; end
            end
            m_s3 = 0; m_prot = 0; m_trig = 0; m_last_addr = -1;
            m_rd[0] = '0; m_rd[1] = '0;
        end else begin
            if (rd) begin
                m_rd[0] = m_read(0, int'(addr));
                m_rd[1] = m_read(1, int'(addr));
                m_last_addr = int'(addr);
            end
            w    = int'(addr) / 4;
            set0 = (m_trig == 0) ? (m_s2[0] && !m_s3) : m_s2[0];
            ack  = wr && w == 4 && wdata[0];
            m_s3 = m_s2[0];
            if (set0)     m_pend[0] = 1;
            else if (ack) m_pend[0] = 0;
            for (int n = 1; n < 96; n++) m_pend[n] = m_s2[n];
            if (wr) begin
                for (int i = 0; i < 2; i++) begin
                    int eb;
                    int mb;
                    eb = (i == 1) ? 8 : 16;
                    mb = (i == 1) ? 12 : 20;
                    if (w >= eb && w < eb + 3)
                        for (int k = 0; k < 32; k++) m_en[i][(w - eb) * 32 + k] = wdata[k];
                    if (w >= mb && w < mb + 3)
                        for (int k = 0; k < 32; k++) m_mk[i][(w - mb) * 32 + k] = wdata[k];
                end
                if (w == 2) m_prot = wdata[0];
                if (w == 3) m_trig = int'(wdata[1:0]);
            end
            for (int n = 0; n < 96; n++) begin
                m_s2[n] = m_s1[n];
                m_s1[n] = src[n];
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            for (int i = 0; i < 2; i++) begin
                bit    exp_irq;
                string t;
                exp_irq = 0;
                for (int n = 0; n < 96; n++) if (m_active(i, n)) exp_irq = 1;
                vecs++;
                t = rst ? "R1" : "R7";
                if (irq[i] !== exp_irq) begin
                    fails++;
                    $display("FAIL %s inst%0d cpu_irq_o actual %b expected %b", t, i, irq[i], exp_irq);
                end
                vecs++;
                t = (rst || m_last_addr < 0) ? "R1" : tag_of(i, m_last_addr);
                if (rdata[i] !== m_rd[i]) begin
                    fails++;
                    $display("FAIL %s inst%0d rdata addr %0h actual %h expected %h",
                             t, i, m_last_addr, rdata[i], m_rd[i]);
                end
            end
        end
    end

    task automatic report();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            fails++;
            $display("FAIL R10 watchdog cycles actual %0d expected below %0d", cyc, 20000);
            report();
        end
    end

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 8'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input int a);
        @(negedge clk);
        addr = 8'(a); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_src(input int n, input bit v);
        @(negedge clk);
        src[n] = v;
    endtask

    initial begin
        rst = 1'b1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; src = '0;
        vecs = 0; fails = 0; cyc = 0; started = 0; finished = 0;
        repeat (2) @(posedge clk);
        started = 1;
        idle(2);
        rst = 1'b0;

        // R1 and R10: sweep the whole map straight after reset
        for (int a = 0; a < 96; a += 4) bus_read(a);

        // R5/R6: enables in both layouts; each write is a no-op in the other copy
        for (int b = 0; b < 3; b++) bus_write(16'h40 + 4 * b, 32'hFFFF_FFFF);
        for (int b = 0; b < 3; b++) bus_write(16'h20 + 4 * b, 32'hFFFF_FFFF);
        for (int a = 32; a < 96; a += 4) bus_read(a);

        // R2/R7/R8: three sources across banks, lowest wins
        drive_src(5, 1); drive_src(40, 1); drive_src(95, 1);
        idle(4);
        bus_read(0); bus_read(16'h10); bus_read(16'h14); bus_read(16'h18);
        drive_src(5, 0); idle(4); bus_read(0);

        // R5/R6: mask source 40 in each layout in turn
        bus_write(16'h54, 32'h0000_0100); bus_read(0);
        bus_write(16'h34, 32'h0000_0100); bus_read(0);
        bus_read(16'h54); bus_read(16'h34);

        // R2: write-one on level sources has no lasting effect
        bus_write(16'h14, 32'hFFFF_FFFF); bus_write(16'h18, 32'hFFFF_FFFF);
        bus_read(16'h14); bus_read(16'h18);

        // R8: writes to the vector are ignored; idle vector reads zero
        bus_write(0, 32'hFFFF_FFFF); bus_read(0);
        drive_src(40, 0); drive_src(95, 0); idle(4); bus_read(0);

        // R3: one-cycle pulse on source 0 is latched, then acknowledged
        drive_src(0, 1); drive_src(0, 0); idle(4);
        bus_read(0); bus_read(16'h10);
        bus_write(16'h10, 32'h0000_0001); bus_read(16'h10);

        // R3: held high, ack clears and no re-arm
        drive_src(0, 1); idle(4); bus_read(16'h10);
        bus_write(16'h10, 32'h0000_0001); idle(3); bus_read(16'h10);
        drive_src(0, 0); idle(4);

        // R3/R8: source 0 beside source 1, then source 0 masked
        drive_src(1, 1); drive_src(0, 1); idle(4); bus_read(0);
        bus_write(16'h50, 32'h0000_0001); bus_write(16'h30, 32'h0000_0001); bus_read(0);
        bus_write(16'h50, 32'h0); bus_write(16'h30, 32'h0);
        drive_src(0, 0); drive_src(1, 0); idle(3);
        bus_write(16'h10, 32'h0000_0001); idle(3); bus_read(16'h10);

        // R4/R9: level trigger mode; ack only works once input drops
        bus_write(16'h0C, 32'hFFFF_FFFF); bus_read(16'h0C);
        drive_src(0, 1); idle(4);
        bus_write(16'h10, 32'h0000_0001); idle(2); bus_read(16'h10);
        drive_src(0, 0); idle(4);
        bus_write(16'h10, 32'h0000_0001); bus_read(16'h10);
        bus_write(16'h0C, 32'h0); bus_read(16'h0C);

        // R9: protection flag
        bus_write(16'h08, 32'hFFFF_FFFF); bus_read(16'h08);
        bus_write(16'h08, 32'h0); bus_read(16'h08);

        // R5: disabling a source silences the line
        drive_src(70, 1); idle(4); bus_read(0);
        bus_write(16'h48, 32'h0); bus_write(16'h28, 32'h0); bus_read(0);
        bus_read(16'h48); bus_read(16'h28);
        drive_src(70, 0);

        // R10: unmapped addresses and ignored low address bits
        bus_read(16'h3D); bus_read(16'h5C); bus_read(16'h0B);
        idle(4);
        report();
    end

endmodule